// File: doc/BRIEF.md
# Network Status LED and GPIO Pin Multiplexer

This block owns three shared pins. Each pin can serve software as a general-purpose pin, or it can show network status as an active-low indicator. As a general-purpose pin it may be an input, a push-pull output or an open-drain output. As an indicator it shows one of three things:

- pin 0 shows the link speed;
- pin 1 shows link presence with activity blinking;
- pin 2 shows duplex.

Status flags come from the PHY. A single-cycle traffic strobe reports each transmit or receive event. A simple write port sets the pin configuration and the output data.

The activity blink is a fixed sequence. Each activity event turns the link indicator off for one window. A mandatory on-window of the same length follows. Activity seen during either window is remembered, and it starts a fresh off-window as soon as the on-window ends. The window length is derived from the clock frequency and a time in microseconds, so simulation can use a few cycles instead of 80 ms. Pin inputs pass through a synchronizer before software can see them.

Top module: `netled_gpio_mux`

## Requirements
- R1: After reset every pin is an input with indicator mode off: pin_oe and pin_do are all zero and both registers read as zero.
- R2: A pin in input mode never drives (pin_oe low). Input mode is mode code 00, and code 11 also means input. The pin_di value shows on pin_in_sync exactly two clock edges after it is applied.
- R3: A pin in push-pull mode (code 01) has pin_oe high and pin_do equal to its bit in the data register.
- R4: A pin in open-drain mode (code 10) has pin_do low and drives only when its data bit is 0, so pin_oe is the inverse of the data bit.
- R5: A pin with its indicator enable set ignores its mode and data bits. It is always open-drain: pin_do is 0, and pin_oe is 1 exactly while the indicator is lit.
- R6: The speed indicator (pin 0) is lit in three cases: 100 Mb/s, auto-negotiation in progress, or cable absent. It is dark only with a 10 Mb/s link, no negotiation and the cable present.
- R7: The duplex indicator (pin 2) is lit only while the link is up and full duplex.
- R8: The link indicator (pin 1) is lit while the link is up and no blink is running. It is released (dark) from the first edge after the link goes down.
- R9: A traffic strobe in the idle lit state darkens the link indicator for exactly WIN clock cycles. It then stays lit for at least WIN cycles.
- R10: A strobe during the dark window or the following lit window starts one new dark window right after that lit window ends. Without such a strobe the indicator stays lit.
- R11: Dropping the link cancels a pending blink. After the link returns, the indicator stays lit until the next strobe.
- R12: Register encoding on the write port: a write with wr_addr 0 loads the configuration. Configuration bits [2p+1:2p] are the mode of pin p, and bits [8+p] enable indicator mode for pin p. A write with wr_addr 1 loads the output data bits [2:0], one per pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_link_up | input | 1 | Valid link detected |
| phy_speed100 | input | 1 | Link runs at 100 Mb/s |
| phy_autoneg_busy | input | 1 | Auto-negotiation in progress |
| phy_cable_present | input | 1 | Cable connected |
| phy_full_duplex | input | 1 | Link is full duplex |
| traffic_strobe | input | 1 | One-cycle pulse per transmit or receive event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects configuration, 1 selects output data |
| wr_data | input | 11 | Write data |
| pin_di | input | 3 | Pin input levels from the pads |
| pin_oe | output | 3 | Pin output enables |
| pin_do | output | 3 | Pin output data |
| pin_in_sync | output | 3 | Synchronized pin input values |

## Verification
A blink sequencer stuck in the wrong state shows up on pin_oe[1] in the first cycle that should be dark or lit. A wrong window count shows up at the exact boundary cycle, WIN cycles after the strobe. A lost or stale pending flag shows up one cycle after the lit window ends, as a missing or extra dark window. Pad slices decoding the wrong mode field or indicator bit show up on pin_oe and pin_do on the clock edge right after the configuration write. A short or long synchronizer shows up one edge early or late on pin_in_sync.

// File: rtl/netled_pkg.sv
package netled_pkg;

   typedef enum logic [1:0] {
      PIN_IN     = 2'b00,
      PIN_PP     = 2'b01,
      PIN_OD     = 2'b10,
      PIN_IN_ALT = 2'b11
   } pin_mode_e;

   typedef enum logic [1:0] {
      BLK_DOWN,
      BLK_ON,
      BLK_OFF,
      BLK_HOLD
   } blink_state_e;

   localparam int LED_SPEED   = 0;
   localparam int LED_LINK    = 1;
   localparam int LED_DUPLEX  = 2;
   localparam int CFG_LED_LSB = 8;

endpackage

// File: rtl/netled_regs.sv
module netled_regs #(
   parameter int NUM_PINS = 3
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         wr_en,
   input  logic                                         wr_addr,
   input  logic [netled_pkg::CFG_LED_LSB+NUM_PINS-1:0]  wr_data,
   output logic [2*NUM_PINS-1:0]                        cfg_mode,
   output logic [NUM_PINS-1:0]                          cfg_led,
   output logic [NUM_PINS-1:0]                          out_data
);
   localparam int LED_LSB = netled_pkg::CFG_LED_LSB;

   if (2 * NUM_PINS > LED_LSB) begin : g_bad_layout
      $error("netled_regs: mode fields overlap the indicator enables");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_mode <= '0;
         cfg_led  <= '0;
         out_data <= '0;
      end else if (wr_en) begin
         if (!wr_addr) begin
            cfg_mode <= wr_data[2*NUM_PINS-1:0];
            cfg_led  <= wr_data[LED_LSB +: NUM_PINS];
         end else begin
            out_data <= wr_data[NUM_PINS-1:0];
         end
      end
   end

endmodule

// File: rtl/netled_sync.sv
module netled_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("netled_sync: at least two stages are required");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/netled_blink.sv
module netled_blink #(
   parameter int WIN_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic link_up,
   input  logic strobe,
   output logic led_on,
   output logic off_window
);
   import netled_pkg::*;

   localparam int CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

   if (WIN_CYCLES < 2) begin : g_bad_win
      $error("netled_blink: window must span at least two cycles");
   end

   blink_state_e state;
   logic [CW-1:0] cnt;
   logic          pending;

   always_ff @(posedge clk) begin
      if (!rst_n || !link_up) begin
         state   <= BLK_DOWN;
         cnt     <= '0;
         pending <= 1'b0;
      end else begin
         unique case (state)
            BLK_DOWN: state <= BLK_ON;
            BLK_ON: begin
               if (strobe) begin
                  state   <= BLK_OFF;
                  cnt     <= '0;
                  pending <= 1'b0;
               end
            end
            BLK_OFF: begin
               if (strobe) pending <= 1'b1;
               if (cnt == LAST) begin
                  state <= BLK_HOLD;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            BLK_HOLD: begin
               if (cnt == LAST) begin
                  cnt     <= '0;
                  pending <= 1'b0;
                  state   <= (pending || strobe) ? BLK_OFF : BLK_ON;
               end else begin
                  cnt <= cnt + 1'b1;
                  if (strobe) pending <= 1'b1;
               end
            end
            default: state <= BLK_DOWN;
         endcase
      end
   end

   assign off_window = (state == BLK_OFF);
   assign led_on     = (state == BLK_ON) || (state == BLK_HOLD);

endmodule

// File: rtl/netled_pad_drive.sv
module netled_pad_drive (
   input  logic [1:0] mode,
   input  logic       led_en,
   input  logic       led_on,
   input  logic       data,
   output logic       oe,
   output logic       dout
);
   import netled_pkg::*;

   always_comb begin
      oe   = 1'b0;
      dout = 1'b0;
      if (led_en) begin
         oe = led_on;
      end else begin
         unique case (pin_mode_e'(mode))
            PIN_PP: begin
               oe   = 1'b1;
               dout = data;
            end
            PIN_OD:  oe = ~data;
            default: oe = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/netled_gpio_mux.sv
module netled_gpio_mux #(
   parameter int NUM_PINS    = 3,
   parameter int CLK_FREQ_HZ = 125_000_000,
   parameter int WINDOW_US   = 80_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         phy_link_up,
   input  logic                                         phy_speed100,
   input  logic                                         phy_autoneg_busy,
   input  logic                                         phy_cable_present,
   input  logic                                         phy_full_duplex,
   input  logic                                         traffic_strobe,
   input  logic                                         wr_en,
   input  logic                                         wr_addr,
   input  logic [netled_pkg::CFG_LED_LSB+NUM_PINS-1:0]  wr_data,
   input  logic [NUM_PINS-1:0]                          pin_di,
   output logic [NUM_PINS-1:0]                          pin_oe,
   output logic [NUM_PINS-1:0]                          pin_do,
   output logic [NUM_PINS-1:0]                          pin_in_sync
);
   import netled_pkg::*;

   localparam int WIN_CYCLES = (CLK_FREQ_HZ / 1_000_000) * WINDOW_US;

   if (NUM_PINS != 3) begin : g_bad_pins
      $error("netled_gpio_mux: indicator map needs exactly three pins");
   end
   if (WIN_CYCLES < 2) begin : g_bad_window
      $error("netled_gpio_mux: blink window shorter than two cycles");
   end

   logic [2*NUM_PINS-1:0] cfg_mode;
   logic [NUM_PINS-1:0]   cfg_led;
   logic [NUM_PINS-1:0]   out_data;
   logic [NUM_PINS-1:0]   led_on;
   logic                  link_lit;
   logic                  act_off;

   netled_regs #(.NUM_PINS(NUM_PINS)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .cfg_mode (cfg_mode),
      .cfg_led  (cfg_led),
      .out_data (out_data)
   );

   netled_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_di),
      .q     (pin_in_sync)
   );

   netled_blink #(.WIN_CYCLES(WIN_CYCLES)) u_blink (
      .clk        (clk),
      .rst_n      (rst_n),
      .link_up    (phy_link_up),
      .strobe     (traffic_strobe),
      .led_on     (link_lit),
      .off_window (act_off)
   );

   always_comb begin
      led_on             = '0;
      led_on[LED_SPEED]  = phy_speed100 | phy_autoneg_busy | ~phy_cable_present;
      led_on[LED_LINK]   = link_lit;
      led_on[LED_DUPLEX] = phy_link_up & phy_full_duplex;
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
      netled_pad_drive u_pad (
         .mode   (cfg_mode[2*p +: 2]),
         .led_en (cfg_led[p]),
         .led_on (led_on[p]),
         .data   (out_data[p]),
         .oe     (pin_oe[p]),
         .dout   (pin_do[p])
      );
   end

endmodule

// File: rtl/netled_gpio_mux_chk.sv
module netled_gpio_mux_chk #(
   parameter int NUM_PINS   = 3,
   parameter int WIN_CYCLES = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  link_up,
   input logic [2*NUM_PINS-1:0] cfg_mode,
   input logic [NUM_PINS-1:0]   cfg_led,
   input logic [NUM_PINS-1:0]   pin_oe,
   input logic [NUM_PINS-1:0]   pin_do,
   input logic                  act_off
);
   localparam int CW = $clog2(WIN_CYCLES + 1);
   localparam logic [CW-1:0] WIN = CW'(WIN_CYCLES);

   logic [CW-1:0] off_run;
   logic [CW-1:0] on_run;
   logic          had_off;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         off_run <= '0;
         on_run  <= '0;
         had_off <= 1'b0;
      end else begin
         off_run <= act_off ? ((off_run == WIN) ? off_run : off_run + 1'b1) : '0;
         if (!link_up) begin
            on_run  <= '0;
            had_off <= 1'b0;
         end else begin
            on_run <= act_off ? '0 : ((on_run == WIN) ? on_run : on_run + 1'b1);
            if (act_off) had_off <= 1'b1;
         end
      end
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [1:0] m;
      assign m = cfg_mode[2*p +: 2];

      assert_input_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_led[p] && (m == 2'b00 || m == 2'b11)) |-> !pin_oe[p]);

      assert_pushpull_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!cfg_led[p] && m == 2'b01) |-> pin_oe[p]);

      assert_led_opendrain_R5: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_led[p] |-> !pin_do[p]);
   end

   assert_link_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up && cfg_led[1]) |=> (!pin_oe[1] || !cfg_led[1]));

   assert_off_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
      act_off |-> (off_run < WIN));

   assert_hold_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(act_off) && had_off) |-> (on_run >= WIN));

endmodule

bind netled_gpio_mux netled_gpio_mux_chk #(
   .NUM_PINS   (NUM_PINS),
   .WIN_CYCLES (WIN_CYCLES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .link_up  (phy_link_up),
   .cfg_mode (cfg_mode),
   .cfg_led  (cfg_led),
   .pin_oe   (pin_oe),
   .pin_do   (pin_do),
   .act_off  (act_off)
);

// File: tb/netled_gpio_mux_test.sv
module netled_gpio_mux_test;

   localparam int WIN = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        link = 1'b0, spd = 1'b0, aneg = 1'b0, cable = 1'b1, fdx = 1'b0;
   logic        act = 1'b0;
   logic        wr_en = 1'b0, wr_addr = 1'b0;
   logic [10:0] wr_data = '0;
   logic [2:0]  pin_di = '0;
   logic [2:0]  pin_oe, pin_do, pin_in_sync;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   netled_gpio_mux #(
      .NUM_PINS(3), .CLK_FREQ_HZ(1_000_000), .WINDOW_US(WIN), .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .phy_link_up(link), .phy_speed100(spd),
      .phy_autoneg_busy(aneg), .phy_cable_present(cable), .phy_full_duplex(fdx),
      .traffic_strobe(act), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pin_di(pin_di), .pin_oe(pin_oe), .pin_do(pin_do), .pin_in_sync(pin_in_sync)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
      end
   endtask

   task automatic step(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(input logic addr, input logic [10:0] data);
      wr_en = 1'b1; wr_addr = addr; wr_data = data;
      step();
      wr_en = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1 oe", 32'(pin_oe), 0);
      chk("R1 do", 32'(pin_do), 0);
      chk("R1 sync", 32'(pin_in_sync), 0);
   endtask

   task automatic t_sync;
      pin_di = 3'b101;
      step();
      chk("R2 sync after one edge", 32'(pin_in_sync), 0);
      step();
      chk("R2 sync after two edges", 32'(pin_in_sync), 32'b101);
      chk("R2 input mode floats", 32'(pin_oe), 0);
   endtask

   task automatic t_pushpull;
      reg_write(1'b0, 11'h015);
      reg_write(1'b1, 11'h005);
      chk("R3 pp oe", 32'(pin_oe), 32'b111);
      chk("R3 R12 pp do", 32'(pin_do), 32'b101);
      reg_write(1'b1, 11'h002);
      chk("R3 pp do second", 32'(pin_do), 32'b010);
   endtask

   task automatic t_opendrain;
      reg_write(1'b0, 11'h02A);
      reg_write(1'b1, 11'h005);
      chk("R4 od oe", 32'(pin_oe), 32'b010);
      chk("R4 od do", 32'(pin_do), 0);
      reg_write(1'b0, 11'h03F);
      chk("R2 code 11 floats", 32'(pin_oe), 0);
   endtask

   task automatic t_speed;
      reg_write(1'b0, 11'h715);
      link = 1'b1; spd = 1'b1; cable = 1'b1; aneg = 1'b0;
      step(2);
      chk("R5 led do forced low", 32'(pin_do), 0);
      chk("R6 speed 100 lit", 32'(pin_oe[0]), 1);
      spd = 1'b0; step();
      chk("R6 speed 10 dark", 32'(pin_oe[0]), 0);
      aneg = 1'b1; step();
      chk("R6 autoneg lit", 32'(pin_oe[0]), 1);
      aneg = 1'b0; cable = 1'b0; step();
      chk("R6 no cable lit", 32'(pin_oe[0]), 1);
      cable = 1'b1; step();
   endtask

   task automatic t_duplex;
      fdx = 1'b1; step();
      chk("R7 full duplex lit", 32'(pin_oe[2]), 1);
      fdx = 1'b0; step();
      chk("R7 half duplex dark", 32'(pin_oe[2]), 0);
   endtask

   task automatic t_link;
      chk("R8 link idle lit", 32'(pin_oe[1]), 1);
      fdx = 1'b1; link = 1'b0; step();
      chk("R8 link down dark", 32'(pin_oe[1]), 0);
      chk("R7 duplex needs link", 32'(pin_oe[2]), 0);
      fdx = 1'b0; link = 1'b1; step();
      chk("R8 link back lit", 32'(pin_oe[1]), 1);
   endtask

   task automatic t_blink(input string req, input int extra_at, input bit repeat_exp);
      act = 1'b1; step(); act = 1'b0;
      for (int i = 0; i <= 2 * WIN; i++) begin
         bit dark;
         dark = (i < WIN) || (i == 2 * WIN && repeat_exp);
         chk(req, 32'(pin_oe[1]), dark ? 0 : 1);
         if (i == extra_at) act = 1'b1;
         step();
         act = 1'b0;
      end
      step(3 * WIN);
   endtask

   task automatic t_linkdrop;
      act = 1'b1; step(); act = 1'b0;
      step(2);
      act = 1'b1; step(); act = 1'b0;
      link = 1'b0; step(2);
      link = 1'b1; step();
      for (int i = 0; i < 3 * WIN; i++) begin
         chk("R11 no blink after link drop", 32'(pin_oe[1]), 1);
         step();
      end
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      step(4);
      rst_n = 1'b1;
      step();
      t_reset();
      t_sync();
      t_pushpull();
      t_opendrain();
      t_speed();
      t_duplex();
      t_link();
      t_blink("R9 single blink window", -1, 1'b0);
      t_blink("R10 strobe in dark window repeats", 3, 1'b1);
      t_blink("R10 strobe in lit window repeats", WIN + 2, 1'b1);
      t_linkdrop();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule